// File: doc/BRIEF.md
# Vector Element Loop Sequencer

This block turns one scalar operation into an ordered series of element operations. On a start pulse it captures a vector length, three base register numbers (one destination, two sources), a scalar/vector tag per operand, an optional predicate mask and an optional data-dependent early-exit test. It then walks the element index upward from 0. For each unmasked element it presents register indices to the register file and the ALU through a valid/ready handshake. A destination write enable marks each element whose result may be stored. The issuing instruction is held until the done pulse, so nothing after it proceeds while elements are still being stepped.

A vector-tagged operand addresses its base register plus the element index. A scalar-tagged operand always addresses its base register. A scalar destination closes the loop after its first stored element. When early exit is on, the sequencer waits for each issued element's condition bits. At the first element that fails the selected test, it stops without storing that element and reports the element index as the shortened length.

The control is a four-state machine. S_IDLE goes to S_RUN on start with a non-zero length, and to S_DONE on start with zero length. S_RUN skips masked elements at one per clock. On a handshake it goes to S_WAIT when early exit is on, to S_DONE after the final element or after a scalar destination's write, and otherwise stays in S_RUN on the next element. S_WAIT returns to S_RUN on a passing result, or goes to S_DONE on a failing result or after the last element. S_DONE always returns to S_IDLE one cycle later.

Top module: `elem_loop_seq`

## Requirements
- R1: Elements are issued in strictly ascending index order, from 0 up to the effective length minus 1, with at most one issue per clock.
- R2: A vector-tagged operand's index is its base plus the element index, modulo 2^REG_W. A scalar-tagged operand's index equals its base.
- R3: With a scalar destination, the loop ends after the first element that is written, and `done` follows on the next cycle.
- R4: When `pred_en` is 1, element i is skipped (not issued) if `pred_mask[i]` is 0. When `pred_en` is 0, the mask is ignored and every element is issued.
- R5: A requested length above MAX_VL (64) is clamped to MAX_VL.
- R6: With `ff_en` set, each issued element waits for `res_valid`. `res_cond` holds lt in bit 0, gt in bit 1 and eq in bit 2. `ff_sel` values 0, 1 and 2 pick those bits, and value 3 picks eq. If the picked bit differs from `ff_expect`, the element is not written, the loop stops, and `vl_out` is that element's index.
- R7: While `issue_valid` is high and `issue_ready` is low, `issue_valid` stays high and the indices stay unchanged.
- R8: A zero length raises `done` in the cycle after `start`, with no element issued.
- R9: `done` is a one-cycle pulse. `vl_out` carries the final length in that cycle: the clamped length, unless early exit truncated it.
- R10: Without early exit, `wr_en` is asserted in each handshake cycle. With early exit, it is asserted in the `res_valid` cycle of a passing element. In both cases the destination index is the one for that element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a loop (accepted when idle) |
| vl_in | input | 7 | Requested element count |
| dst_base | input | 7 | Destination base register |
| srca_base | input | 7 | First source base register |
| srcb_base | input | 7 | Second source base register |
| dst_vec | input | 1 | Destination is vector-tagged |
| srca_vec | input | 1 | First source is vector-tagged |
| srcb_vec | input | 1 | Second source is vector-tagged |
| pred_en | input | 1 | Apply predicate mask |
| pred_mask | input | 64 | Per-element enable bits |
| ff_en | input | 1 | Data-dependent early exit on |
| ff_sel | input | 2 | Condition bit selector |
| ff_expect | input | 1 | Value the selected bit must have |
| issue_ready | input | 1 | ALU accepts the presented element |
| res_valid | input | 1 | Condition bits of the outstanding element are valid |
| res_cond | input | 3 | {eq, gt, lt} of the outstanding element |
| issue_valid | output | 1 | An element is presented |
| elem_idx | output | 6 | Current element index |
| dst_idx | output | 7 | Destination register index |
| srca_idx | output | 7 | First source register index |
| srcb_idx | output | 7 | Second source register index |
| wr_en | output | 1 | Destination write allowed for this element |
| done | output | 1 | Loop finished (one-cycle pulse) |
| vl_out | output | 7 | Final element count |

## Verification
The sweep covers all eight scalar/vector tag combinations. This separates an operand that steps from one that stays on its base, and shows the scalar-destination single-write exit. Lengths of 0, 1, 5, 64 and 70 exercise the empty loop, the one-element loop, a short loop, the full limit and the clamp. Base numbers near the top of the register space show index wrap. Three predicate settings are used: disabled over a zero mask, alternating bits, and a mask that starts with a cleared element. Together they show that masking is ignored when disabled and that skipping works, including at element 0. Each run also sets the ALU to accept every cycle or to stall every third cycle, and sets early exit off or on with the failing element placed mid-loop. In the early-exit runs the non-selected condition bits always disagree with the expected value, so a wrong bit choice becomes visible.

// File: rtl/elem_seq_pkg.sv
package elem_seq_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_WAIT = 2'd2,
        S_DONE = 2'd3
    } seq_state_e;

    // bit 0 = lt, bit 1 = gt, bit 2 = eq; selector 3 also means eq
    function automatic logic cond_pick(input logic [2:0] c, input logic [1:0] sel);
        logic r;
        unique case (sel)
            2'd0:    r = c[0];
            2'd1:    r = c[1];
            default: r = c[2];
        endcase
        return r;
    endfunction

endpackage

// File: rtl/elem_vl_clamp.sv
module elem_vl_clamp #(
    parameter int MAX_VL = 64,
    parameter int VL_W   = 7
) (
    input  logic [VL_W-1:0] vl_req,
    output logic [VL_W-1:0] vl_eff
);
    localparam logic [VL_W-1:0] LIMIT = VL_W'(MAX_VL);

    always_comb begin
        vl_eff = (vl_req > LIMIT) ? LIMIT : vl_req;
    end

    always_comb begin
        p_clamp_r5: assert (vl_eff <= LIMIT);
    end
endmodule

// File: rtl/elem_opnd_idx.sv
module elem_opnd_idx #(
    parameter int REG_W = 7,
    parameter int IDX_W = 6
) (
    input  logic [REG_W-1:0] base,
    input  logic             is_vec,
    input  logic [IDX_W-1:0] elem,
    output logic [REG_W-1:0] idx
);
    always_comb begin
        idx = base + (is_vec ? REG_W'(elem) : '0);
    end
endmodule

// File: rtl/elem_ff_check.sv
module elem_ff_check
    import elem_seq_pkg::*;
(
    input  logic [2:0] cond,
    input  logic [1:0] sel,
    input  logic       expect_val,
    output logic       pass
);
    always_comb begin
        pass = (cond_pick(cond, sel) == expect_val);
    end
endmodule

// File: rtl/elem_seq_fsm.sv
module elem_seq_fsm
    import elem_seq_pkg::*;
#(
    parameter int MAX_VL = 64,
    parameter int IDX_W  = 6,
    parameter int VL_W   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [VL_W-1:0]   vl_eff,
    input  logic [MAX_VL-1:0] mask_in,
    input  logic              ff_in,
    input  logic              dvec_q,
    input  logic              issue_ready,
    input  logic              res_valid,
    input  logic              ff_pass,
    output logic              load,
    output logic [IDX_W-1:0]  elem,
    output logic              issue_valid,
    output logic              wr_en,
    output logic              done,
    output logic [VL_W-1:0]   vl_out
);
    seq_state_e        state, state_n;
    logic [IDX_W-1:0]  idx_n;
    logic [VL_W-1:0]   vl_q, vlo_n;
    logic [MAX_VL-1:0] mask_q;
    logic              ff_q;
    logic              last, live;

    always_comb begin
        last = (VL_W'(elem) == (vl_q - VL_W'(1)));
        live = mask_q[elem];
    end

    // next-state and counter logic
    always_comb begin
        state_n = state;
        idx_n   = elem;
        vlo_n   = vl_out;
        unique case (state)
            S_IDLE: begin
                if (start) begin
                    idx_n = '0;
                    if (vl_eff == '0) begin
                        state_n = S_DONE;
                        vlo_n   = '0;
                    end else begin
                        state_n = S_RUN;
                    end
                end
            end
            S_RUN: begin
                if (!live) begin
                    if (last) begin
                        state_n = S_DONE;
                        vlo_n   = vl_q;
                    end else begin
                        idx_n = elem + IDX_W'(1);
                    end
                end else if (issue_ready) begin
                    if (ff_q) begin
                        state_n = S_WAIT;
                    end else if (!dvec_q || last) begin
                        state_n = S_DONE;
                        vlo_n   = vl_q;
                    end else begin
                        idx_n = elem + IDX_W'(1);
                    end
                end
            end
            S_WAIT: begin
                if (res_valid) begin
                    if (!ff_pass) begin
                        state_n = S_DONE;
                        vlo_n   = VL_W'(elem);
                    end else if (!dvec_q || last) begin
                        state_n = S_DONE;
                        vlo_n   = vl_q;
                    end else begin
                        state_n = S_RUN;
                        idx_n   = elem + IDX_W'(1);
                    end
                end
            end
            S_DONE:  state_n = S_IDLE;
            default: state_n = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            elem   <= '0;
            vl_out <= '0;
            vl_q   <= '0;
            mask_q <= '0;
            ff_q   <= 1'b0;
        end else begin
            state  <= state_n;
            elem   <= idx_n;
            vl_out <= vlo_n;
            if (load) begin
                vl_q   <= vl_eff;
                mask_q <= mask_in;
                ff_q   <= ff_in;
            end
        end
    end

    // outputs
    always_comb begin
        load        = (state == S_IDLE) && start;
        issue_valid = (state == S_RUN) && live;
        wr_en       = ((state == S_RUN) && live && issue_ready && !ff_q) ||
                      ((state == S_WAIT) && res_valid && ff_pass);
        done        = (state == S_DONE);
    end

    // order tracking for the checks below
    logic [IDX_W-1:0] prev_elem;
    logic             prev_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_elem <= '0;
            prev_ok   <= 1'b0;
        end else if (load) begin
            prev_ok <= 1'b0;
        end else if (issue_valid && issue_ready) begin
            prev_elem <= elem;
            prev_ok   <= 1'b1;
        end
    end

    p_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && prev_ok && !(issue_ready && $past(issue_valid && !issue_ready)))
        |-> (elem > prev_elem || (elem == prev_elem && $past(issue_valid && !issue_ready))));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !issue_ready) |=> (issue_valid && $stable(elem)));

    p_scalar_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !dvec_q) |=> done);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_trunc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (vl_out <= vl_q));

    p_zero_vl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (load && vl_eff == '0) |=> (done && !issue_valid));
endmodule

// File: rtl/elem_loop_seq.sv
module elem_loop_seq #(
    parameter int MAX_VL = 64,
    parameter int REG_W  = 7,
    localparam int IDX_W = $clog2(MAX_VL),
    localparam int VL_W  = $clog2(MAX_VL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [VL_W-1:0]   vl_in,
    input  logic [REG_W-1:0]  dst_base,
    input  logic [REG_W-1:0]  srca_base,
    input  logic [REG_W-1:0]  srcb_base,
    input  logic              dst_vec,
    input  logic              srca_vec,
    input  logic              srcb_vec,
    input  logic              pred_en,
    input  logic [MAX_VL-1:0] pred_mask,
    input  logic              ff_en,
    input  logic [1:0]        ff_sel,
    input  logic              ff_expect,
    input  logic              issue_ready,
    input  logic              res_valid,
    input  logic [2:0]        res_cond,
    output logic              issue_valid,
    output logic [IDX_W-1:0]  elem_idx,
    output logic [REG_W-1:0]  dst_idx,
    output logic [REG_W-1:0]  srca_idx,
    output logic [REG_W-1:0]  srcb_idx,
    output logic              wr_en,
    output logic              done,
    output logic [VL_W-1:0]   vl_out
);
    localparam int N_OPND = 3;

    logic              load;
    logic [VL_W-1:0]   vl_eff;
    logic [MAX_VL-1:0] mask_eff;
    logic              ff_pass;
    logic [1:0]        sel_q;
    logic              exp_q;

    logic [REG_W-1:0] base_in [N_OPND];
    logic             vec_in  [N_OPND];
    logic [REG_W-1:0] base_q  [N_OPND];
    logic             vec_q   [N_OPND];
    logic [REG_W-1:0] idx_out [N_OPND];

    always_comb begin
        base_in[0] = dst_base;  vec_in[0] = dst_vec;
        base_in[1] = srca_base; vec_in[1] = srca_vec;
        base_in[2] = srcb_base; vec_in[2] = srcb_vec;
        mask_eff   = pred_en ? pred_mask : '1;
    end

    elem_vl_clamp #(.MAX_VL(MAX_VL), .VL_W(VL_W)) u_clamp (
        .vl_req (vl_in),
        .vl_eff (vl_eff)
    );

    for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                base_q[g] <= '0;
                vec_q[g]  <= 1'b0;
            end else if (load) begin
                base_q[g] <= base_in[g];
                vec_q[g]  <= vec_in[g];
            end
        end

        elem_opnd_idx #(.REG_W(REG_W), .IDX_W(IDX_W)) u_idx (
            .base   (base_q[g]),
            .is_vec (vec_q[g]),
            .elem   (elem_idx),
            .idx    (idx_out[g])
        );

        p_scalar_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (issue_valid && !vec_q[g]) |-> (idx_out[g] == base_q[g]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
            exp_q <= 1'b0;
        end else if (load) begin
            sel_q <= ff_sel;
            exp_q <= ff_expect;
        end
    end

    elem_ff_check u_ff (
        .cond       (res_cond),
        .sel        (sel_q),
        .expect_val (exp_q),
        .pass       (ff_pass)
    );

    elem_seq_fsm #(.MAX_VL(MAX_VL), .IDX_W(IDX_W), .VL_W(VL_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .vl_eff      (vl_eff),
        .mask_in     (mask_eff),
        .ff_in       (ff_en),
        .dvec_q      (vec_q[0]),
        .issue_ready (issue_ready),
        .res_valid   (res_valid),
        .ff_pass     (ff_pass),
        .load        (load),
        .elem        (elem_idx),
        .issue_valid (issue_valid),
        .wr_en       (wr_en),
        .done        (done),
        .vl_out      (vl_out)
    );

    always_comb begin
        dst_idx  = idx_out[0];
        srca_idx = idx_out[1];
        srcb_idx = idx_out[2];
    end
endmodule

// File: tb/sim_elem_loop_seq.sv
module sim_elem_loop_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        start = 0;
    logic [6:0]  vl_in = 0;
    logic [6:0]  dst_base = 0, srca_base = 0, srcb_base = 0;
    logic        dst_vec = 0, srca_vec = 0, srcb_vec = 0;
    logic        pred_en = 0;
    logic [63:0] pred_mask = 0;
    logic        ff_en = 0;
    logic [1:0]  ff_sel = 0;
    logic        ff_expect = 0;
    logic        issue_ready = 0, res_valid = 0;
    logic [2:0]  res_cond = 0;
    logic        issue_valid, wr_en, done;
    logic [5:0]  elem_idx;
    logic [6:0]  dst_idx, srca_idx, srcb_idx, vl_out;

    elem_loop_seq u0 (.*);

    int checks = 0, errors = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    // ALU model controls
    bit stall_mode = 0;
    int fail_at = -1;
    bit hs_seen = 0;
    int hs_elem = 0;
    always @(posedge clk) begin
        #1;
        issue_ready = stall_mode ? ((cyc % 3) != 0) : 1'b1;
        res_valid   = hs_seen;
        if (hs_seen) begin
            res_cond = {3{ff_expect}};
            res_cond = res_cond ^ 3'b111;
            res_cond[(ff_sel == 2'd3) ? 2 : ff_sel] = (hs_elem == fail_at) ? ~ff_expect : ff_expect;
        end
    end

    // monitor
    int n_iss = 0, n_wr = 0, n_done = 0, done_cyc = 0, got_vl = 0;
    int iss_e [64], iss_d [64], iss_a [64], iss_b [64];
    int wr_d [64];
    always @(negedge clk) begin
        hs_seen = issue_valid && issue_ready;
        hs_elem = elem_idx;
        if (rst_n) begin
            if (issue_valid && issue_ready && n_iss < 64) begin
                iss_e[n_iss] = elem_idx; iss_d[n_iss] = dst_idx;
                iss_a[n_iss] = srca_idx; iss_b[n_iss] = srcb_idx;
                n_iss++;
            end
            if (wr_en && n_wr < 64) begin
                wr_d[n_wr] = dst_idx;
                n_wr++;
            end
            if (done) begin
                n_done++;
                done_cyc = cyc;
                got_vl = vl_out;
            end
        end
    end

    task automatic run_case(input int vl, input bit dv, input bit av, input bit bv,
                            input int db, input int ab, input int bb,
                            input bit pe, input logic [63:0] pm,
                            input bit ff, input int fsel, input bit fexp, input int fat,
                            input bit stl);
        int vlc, exp_vl, en, ew, st_cyc, w;
        int ee [64];
        int ewr [64];
        bit stop;
        vlc = (vl > 64) ? 64 : vl;
        exp_vl = vlc; en = 0; ew = 0; stop = 0;
        for (int i = 0; i < vlc; i++) begin
            if (!stop && (!pe || pm[i])) begin
                ee[en] = i; en++;
                if (ff && i == fat) begin
                    exp_vl = i; stop = 1;
                end else begin
                    ewr[ew] = i; ew++;
                    if (!dv) stop = 1;
                end
            end
        end
        @(posedge clk); #1;
        vl_in = 7'(vl); dst_vec = dv; srca_vec = av; srcb_vec = bv;
        dst_base = 7'(db); srca_base = 7'(ab); srcb_base = 7'(bb);
        pred_en = pe; pred_mask = pm; ff_en = ff; ff_sel = 2'(fsel); ff_expect = fexp;
        fail_at = fat; stall_mode = stl;
        n_iss = 0; n_wr = 0; n_done = 0;
        start = 1; st_cyc = cyc;
        @(posedge clk); #1;
        start = 0;
        w = 0;
        while (n_done == 0 && w < 1000) begin
            @(posedge clk); w++;
        end
        if (n_done == 0) chk(0, "R9 watchdog", 0, 1);
        repeat (3) @(posedge clk);
        #1;
        chk(n_done == 1, "R9 done pulses", n_done, 1);
        chk(got_vl == exp_vl, (ff ? "R6 final vl" : "R5 final vl"), got_vl, exp_vl);
        chk(n_iss == en, "R4 issue count", n_iss, en);
        for (int k = 0; k < en && k < n_iss; k++) begin
            chk(iss_e[k] == ee[k], "R1 element order", iss_e[k], ee[k]);
            chk(iss_d[k] == ((db + (dv ? ee[k] : 0)) % 128), "R2 dst index", iss_d[k], (db + (dv ? ee[k] : 0)) % 128);
            chk(iss_a[k] == ((ab + (av ? ee[k] : 0)) % 128), "R2 srca index", iss_a[k], (ab + (av ? ee[k] : 0)) % 128);
            chk(iss_b[k] == ((bb + (bv ? ee[k] : 0)) % 128), "R2 srcb index", iss_b[k], (bb + (bv ? ee[k] : 0)) % 128);
        end
        chk(n_wr == ew, (dv ? "R10 write count" : "R3 scalar write count"), n_wr, ew);
        for (int k = 0; k < ew && k < n_wr; k++)
            chk(wr_d[k] == ((db + (dv ? ewr[k] : 0)) % 128), "R10 write index", wr_d[k], (db + (dv ? ewr[k] : 0)) % 128);
        if (vlc == 0)
            chk(done_cyc == st_cyc + 1, "R8 zero length done timing", done_cyc, st_cyc + 1);
    endtask

    initial begin
        int vls [5];
        logic [63:0] pms [3];
        vls[0] = 0; vls[1] = 1; vls[2] = 5; vls[3] = 64; vls[4] = 70;
        pms[0] = 64'h0;
        pms[1] = 64'hAAAA_5555_AAAA_5555;
        pms[2] = 64'hF0F0_F0F0_F0F0_F0F0;
        repeat (3) @(posedge clk);
        #1;
        chk(!issue_valid, "R7 reset issue_valid", issue_valid, 0);
        chk(!done, "R9 reset done", done, 0);
        chk(!wr_en, "R10 reset wr_en", wr_en, 0);
        rst_n = 1;
        #1;
        chk(vl_out == 0, "R9 reset vl_out", vl_out, 0);
        for (int c = 0; c < 8; c++)
            for (int v = 0; v < 5; v++)
                for (int p = 0; p < 3; p++)
                    for (int f = 0; f < 2; f++) begin
                        int vc;
                        vc = (vls[v] > 64) ? 64 : vls[v];
                        run_case(vls[v], c[2], c[1], c[0],
                                 c * 9 + 3, 100 + v, 120,
                                 (p != 0), pms[p],
                                 f[0], (c + p) % 4, p[0], (f != 0) ? vc / 2 : -1,
                                 (c[0] ^ p[0]));
                    end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 190000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule